// File: doc/BRIEF.md
# Interleaved YCbCr Embedded-Sync Demultiplexer

This block accepts progressive-scan video in which luma and both chroma components share one 10-bit word per clock. In embedded mode it searches the stream for four-word timing codes, decodes their field, vertical-blank and line-phase flags, removes the code words, and hands each active sample either to a luma output or to a chroma output. The chroma output has a flag that marks Cr against Cb. A pixel-order input chooses whether the first active sample after a start-of-line code is luma (luma, Cb, luma, Cr) or Cb (Cb, luma, Cr, luma).

The block measures line length, active length, lines per frame and active lines per frame while it tracks the codes. Lock is declared once a full frame has been measured. If Cb-first order is then selected, the block free-runs: it makes its own timing events from the latched measurements and ignores whatever codes the stream still carries. In separate-sync mode no codes are decoded. Timing then comes from external blank, horizontal and vertical sync inputs.

All outputs are registered. A word that enters on `din` reaches the luma or chroma output four clocks later. The same delay applies to the external sync inputs.

Top module: `ycc_sync_demux`

## Requirements
- R1: A timing code is 3FF, 000, 000 followed by a word with bit 9 = 1, whose bit 8 is the field flag, bit 7 the vertical-blank flag and bit 6 the line phase (0 = start of active video, 1 = end of active video). `field_o`, `vsync_o` and `hsync_o` show the flags of the last decoded code.
- R2: None of the four words of a timing code is ever output as a sample. A 3FF that is not followed by 000, 000 and a word with bit 9 set is passed on as ordinary data.
- R3: Samples are output only between a start-of-active code with vertical-blank = 0 and the next end-of-active code. Lines opened with vertical-blank = 1 produce no samples.
- R4: With `align_cb` = 0, the active samples of a line go to luma, Cb, luma, Cr, repeating. On the chroma output `c_is_cr` = 0 marks Cb and 1 marks Cr. Only one of `y_valid` and `c_valid` is high in any cycle.
- R5: With `align_cb` = 1 the order is Cb, luma, Cr, luma, repeating.
- R6: A sample presented on `din` appears on `y_data` or `c_data`, with its strobe, four clock cycles later.
- R7: A frame start is the first start-of-active code with vertical-blank = 0 after one with vertical-blank = 1. `locked` rises at the second frame start after reset.
- R8: When `locked` = 1, `align_cb` = 1 and `sep_sync` = 0, `free_run` is high. Timing then comes from the latched line and frame measurements, and codes in the stream are ignored, so a stream with no codes still gives the same number of samples per frame.
- R9: With `sep_sync` = 1 no codes are decoded. A sample is output wherever the delayed `ext_blank` is low, the sample order restarts at each falling edge of blank, and `hsync_o`/`vsync_o` follow the external inputs.
- R10: A synchronous `rst` clears lock and free-run, drops both strobes and returns the block to code search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one word per cycle |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 10 | Interleaved sample or timing-code word |
| align_cb | input | 1 | 0: luma first after a code; 1: Cb first (enables free-run once locked) |
| sep_sync | input | 1 | 1: use the external sync inputs and ignore codes |
| ext_hsync | input | 1 | External horizontal sync (separate-sync mode) |
| ext_vsync | input | 1 | External vertical sync (separate-sync mode) |
| ext_blank | input | 1 | External blank, high outside active video |
| y_data | output | 10 | Luma sample |
| y_valid | output | 1 | One-cycle strobe for y_data |
| c_data | output | 10 | Chroma sample |
| c_valid | output | 1 | One-cycle strobe for c_data |
| c_is_cr | output | 1 | 1 = Cr, 0 = Cb on c_data |
| hsync_o | output | 1 | Recovered line-phase flag |
| vsync_o | output | 1 | Recovered vertical-blank flag |
| field_o | output | 1 | Recovered field flag |
| locked | output | 1 | Timing measurements are valid |
| free_run | output | 1 | Timing is generated from the latched measurements |

## Verification
Ramp-valued lines are sent in both sample orders with several base values. Each word then has a unique value, so the bench can tell a swap of luma and chroma, a Cb/Cr mix-up and a leaked code word apart. A line that holds a stray 3FF, and a partial code, shows that only the full four-word pattern is stripped, and a vertical-blank line must stay silent. A constant stream with no codes at all, sent after lock and Cb-first selection, separates a design that free-runs from one that still waits for codes. A separate-sync line whose data contains a code pattern shows that decoding is off and gives the four-cycle latency.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  // number of words in an embedded timing code (fixed by the stream format)
  localparam int TRS_LEN = 4;

  typedef struct packed {
    logic f;   // field
    logic v;   // vertical blank
    logic h;   // 1 = end of active video, 0 = start
  } tflags_t;
endpackage

// File: rtl/ycc_trs_detect.sv
module ycc_trs_detect
  import ycc_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  input  logic         hs_in,
  input  logic         vs_in,
  input  logic         bl_in,
  output logic         hit,
  output tflags_t      flg,
  output logic [W-1:0] word_d,
  output logic         hs_d,
  output logic         vs_d,
  output logic         bl_d
);
  localparam int DEPTH = TRS_LEN - 1;
  localparam int BW    = W + 3;
  localparam logic [BW-1:0] PIPE_RST = {3'b001, {W{1'b0}}};

  // delay line {hs, vs, blank, word}; its length equals the code prefix
  logic [BW-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= PIPE_RST;
    else     pipe[0] <= {hs_in, vs_in, bl_in, din};
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= PIPE_RST;
      else     pipe[i] <= pipe[i-1];
    end
  end

  always_comb begin
    hit = en && (pipe[DEPTH-1][W-1:0] == {W{1'b1}})
             && (pipe[DEPTH-2][W-1:0] == '0)
             && (pipe[DEPTH-3][W-1:0] == '0)
             && din[W-1];
    flg.f = din[W-2];
    flg.v = din[W-3];
    flg.h = din[W-4];
  end

  assign word_d = pipe[DEPTH-1][W-1:0];
  assign bl_d   = pipe[DEPTH-1][W];
  assign vs_d   = pipe[DEPTH-1][W+1];
  assign hs_d   = pipe[DEPTH-1][W+2];
endmodule

// File: rtl/ycc_timing.sv
module ycc_timing
  import ycc_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    en,
  input  logic    align,
  input  logic    hit_in,
  input  tflags_t flg_in,
  output logic    ev_hit,
  output tflags_t ev_flg,
  output logic    locked,
  output logic    free_run
);
  logic [HW-1:0] hpos, line_len, act_len;
  logic [VW-1:0] vpos, vnext, frame_lines, vact_cnt, vact_len;
  logic          prev_v, seen_once, f_q;
  logic          v_sav, v_eav, sav, frame_start;

  assign free_run = en && align && locked;
  assign v_sav    = (hpos == line_len - 1'b1);
  assign v_eav    = (hpos == act_len);
  assign vnext    = (vpos + 1'b1 == frame_lines) ? '0 : vpos + 1'b1;

  always_comb begin
    if (free_run) begin
      ev_hit   = v_sav || v_eav;
      ev_flg.f = f_q;
      ev_flg.h = !v_sav;
      ev_flg.v = v_sav ? (vnext >= vact_len) : (vpos >= vact_len);
    end else begin
      ev_hit = en && hit_in;
      ev_flg = flg_in;
    end
    sav         = ev_hit && !ev_flg.h;
    frame_start = !free_run && sav && !ev_flg.v && prev_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos <= '0; line_len <= '0; act_len <= '0;
      vpos <= '0; frame_lines <= '0; vact_cnt <= '0; vact_len <= '0;
      prev_v <= 1'b0; seen_once <= 1'b0; f_q <= 1'b0; locked <= 1'b0;
    end else begin
      hpos <= sav ? '0 : hpos + 1'b1;
      if (sav) vpos <= free_run ? vnext : (frame_start ? '0 : vpos + 1'b1);
      if (!free_run && ev_hit) begin
        if (ev_flg.h) begin
          act_len <= hpos;
        end else begin
          line_len <= hpos + 1'b1;
          prev_v   <= ev_flg.v;
          if (frame_start) begin
            frame_lines <= vpos + 1'b1;
            vact_len    <= vact_cnt;
            vact_cnt    <= VW'(1);
            f_q         <= ev_flg.f;
            seen_once   <= 1'b1;
            if (seen_once) locked <= 1'b1;
          end else if (!ev_flg.v) begin
            vact_cnt <= vact_cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    free_run && $past(free_run) |-> $stable(line_len) && $stable(act_len)); // R8
  AST_RST_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !locked); // R10
  AST_LOCK_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(frame_start)); // R7
endmodule

// File: rtl/ycc_router.sv
module ycc_router
  import ycc_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_mode,
  input  logic         align,
  input  logic         ev_hit,
  input  tflags_t      ev_flg,
  input  logic [W-1:0] word,
  input  logic         hs_d,
  input  logic         vs_d,
  input  logic         bl_d,
  output logic [W-1:0] y_data,
  output logic         y_valid,
  output logic [W-1:0] c_data,
  output logic         c_valid,
  output logic         c_is_cr,
  output logic         hs_o,
  output logic         vs_o,
  output logic         f_o
);
  localparam int KW = $clog2(TRS_LEN);

  logic [KW-1:0] kill_cnt;
  logic [1:0]    phase, ph_now;
  logic          act_q, h_q, v_q, f_q, bl_prev;
  logic          kill, emit, restart, is_y;

  always_comb begin
    kill    = ev_hit || (kill_cnt != '0);
    restart = ext_mode && bl_prev && !bl_d;
    emit    = ext_mode ? !bl_d : (act_q && !kill);
    ph_now  = restart ? 2'd0 : phase;
    is_y    = align ? ph_now[0] : !ph_now[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kill_cnt <= '0; phase <= '0; act_q <= 1'b0;
      h_q <= 1'b1; v_q <= 1'b1; f_q <= 1'b0; bl_prev <= 1'b1;
      y_data <= '0; y_valid <= 1'b0; c_data <= '0; c_valid <= 1'b0;
      c_is_cr <= 1'b0; hs_o <= 1'b1; vs_o <= 1'b1; f_o <= 1'b0;
    end else begin
      bl_prev <= bl_d;
      if (ev_hit && !ext_mode) begin
        kill_cnt <= KW'(TRS_LEN - 1);
        act_q    <= !ev_flg.h && !ev_flg.v;
        h_q <= ev_flg.h; v_q <= ev_flg.v; f_q <= ev_flg.f;
      end else if (kill_cnt != '0) begin
        kill_cnt <= kill_cnt - 1'b1;
      end
      if (ev_hit && !ev_flg.h && !ext_mode) phase <= '0;
      else if (emit)                        phase <= ph_now + 1'b1;
      y_valid <= emit && is_y;
      c_valid <= emit && !is_y;
      if (emit && is_y)  y_data <= word;
      if (emit && !is_y) begin
        c_data  <= word;
        c_is_cr <= ph_now[1];
      end
      hs_o <= ext_mode ? hs_d : h_q;
      vs_o <= ext_mode ? vs_d : v_q;
      f_o  <= ext_mode ? 1'b0 : f_q;
    end
  end

  AST_Y_C_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(y_valid && c_valid)); // R4
  AST_NO_CODE_OUT: assert property (@(posedge clk) disable iff (rst)
    !ext_mode && ev_hit |=> !y_valid && !c_valid); // R2
endmodule

// File: rtl/ycc_sync_demux.sv
module ycc_sync_demux
  import ycc_pkg::*;
#(
  parameter int W  = 10,
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         align_cb,
  input  logic         sep_sync,
  input  logic         ext_hsync,
  input  logic         ext_vsync,
  input  logic         ext_blank,
  output logic [W-1:0] y_data,
  output logic         y_valid,
  output logic [W-1:0] c_data,
  output logic         c_valid,
  output logic         c_is_cr,
  output logic         hsync_o,
  output logic         vsync_o,
  output logic         field_o,
  output logic         locked,
  output logic         free_run
);
  logic         det_hit, ev_hit, hs_d, vs_d, bl_d;
  tflags_t      det_flg, ev_flg;
  logic [W-1:0] word_d;

  ycc_trs_detect #(.W(W)) u_det (
    .clk(clk), .rst(rst), .en(!sep_sync), .din(din),
    .hs_in(ext_hsync), .vs_in(ext_vsync), .bl_in(ext_blank),
    .hit(det_hit), .flg(det_flg), .word_d(word_d),
    .hs_d(hs_d), .vs_d(vs_d), .bl_d(bl_d)
  );

  ycc_timing #(.HW(HW), .VW(VW)) u_tim (
    .clk(clk), .rst(rst), .en(!sep_sync), .align(align_cb),
    .hit_in(det_hit), .flg_in(det_flg), .ev_hit(ev_hit), .ev_flg(ev_flg),
    .locked(locked), .free_run(free_run)
  );

  ycc_router #(.W(W)) u_rt (
    .clk(clk), .rst(rst), .ext_mode(sep_sync), .align(align_cb),
    .ev_hit(ev_hit), .ev_flg(ev_flg), .word(word_d),
    .hs_d(hs_d), .vs_d(vs_d), .bl_d(bl_d),
    .y_data(y_data), .y_valid(y_valid), .c_data(c_data), .c_valid(c_valid),
    .c_is_cr(c_is_cr), .hs_o(hsync_o), .vs_o(vsync_o), .f_o(field_o)
  );
endmodule

// File: tb/ycc_sync_demux_tb.sv
module ycc_sync_demux_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] din = '0;
  logic align_cb = 1'b0, sep_sync = 1'b0;
  logic ext_hsync = 1'b1, ext_vsync = 1'b0, ext_blank = 1'b1;
  logic [9:0] y_data, c_data;
  logic y_valid, c_valid, c_is_cr, hsync_o, vsync_o, field_o, locked, free_run;

  always #2 clk = ~clk;  // 250 MHz

  ycc_sync_demux u_dut (
    .clk(clk), .rst(rst), .din(din), .align_cb(align_cb), .sep_sync(sep_sync),
    .ext_hsync(ext_hsync), .ext_vsync(ext_vsync), .ext_blank(ext_blank),
    .y_data(y_data), .y_valid(y_valid), .c_data(c_data), .c_valid(c_valid),
    .c_is_cr(c_is_cr), .hsync_o(hsync_o), .vsync_o(vsync_o), .field_o(field_o),
    .locked(locked), .free_run(free_run)
  );

  int nchk = 0, nerr = 0, cyc = 0, y_cnt = 0, c_cnt = 0, y_first = -1;
  logic [9:0] y_buf [16];
  logic [9:0] c_buf [16];
  logic       cr_buf [16];
  bit done = 0;

  // {align, base value} for the routing table
  localparam logic [10:0] RCASE [4] = '{
    {1'b0, 10'h010}, {1'b1, 10'h010}, {1'b0, 10'h2A0}, {1'b1, 10'h155}
  };

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (y_valid) begin
      if (y_first < 0) y_first = cyc;
      if (y_cnt < 16) y_buf[y_cnt] = y_data;
      y_cnt++;
    end
    if (c_valid) begin
      if (c_cnt < 16) begin c_buf[c_cnt] = c_data; cr_buf[c_cnt] = c_is_cr; end
      c_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] w);
    @(negedge clk); din = w;
  endtask

  task automatic send_code(input logic f, input logic v, input logic h);
    drive(10'h3FF); drive(10'h000); drive(10'h000);
    drive({1'b1, f, v, h, 6'b0});
  endtask

  task automatic send_line(input logic v, input logic f, input logic [9:0] act [8]);
    send_code(f, v, 1'b1);
    for (int i = 0; i < 4; i++) drive(10'h040);
    send_code(f, v, 1'b0);
    for (int i = 0; i < 8; i++) drive(act[i]);
  endtask

  task automatic ramp_line(input logic v, input logic [9:0] base);
    logic [9:0] a [8];
    for (int i = 0; i < 8; i++) a[i] = base + 10'(i);
    send_line(v, 1'b0, a);
  endtask

  task automatic send_frame();
    ramp_line(1'b1, 10'h080); ramp_line(1'b1, 10'h080);
    ramp_line(1'b0, 10'h080); ramp_line(1'b0, 10'h090); ramp_line(1'b0, 10'h0A0);
  endtask

  task automatic close_line(input logic f, input logic v);
    send_code(f, v, 1'b1);
    for (int i = 0; i < 6; i++) drive(10'h040);
  endtask

  task automatic clr();
    @(posedge clk); y_cnt = 0; c_cnt = 0; y_first = -1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; din = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic ext_drive(input logic [9:0] w, input logic bl);
    @(negedge clk); din = w; ext_blank = bl; ext_hsync = bl; ext_vsync = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 y_valid at reset", y_valid, 0);
    check("R10 c_valid at reset", c_valid, 0);
    check("R10 locked at reset", locked, 0);
    check("R10 free_run at reset", free_run, 0);
    rst = 1'b0;

    // routing table, R4 / R5 / R2
    foreach (RCASE[k]) begin
      logic [9:0] b;
      logic al;
      al = RCASE[k][10];
      b = RCASE[k][9:0];
      align_cb = al;
      clr();
      ramp_line(1'b0, b);
      close_line(1'b0, 1'b0);
      check(al ? "R5 y count" : "R4 y count", y_cnt, 4);
      check(al ? "R5 c count" : "R4 c count", c_cnt, 4);
      for (int i = 0; i < 4; i++) begin
        check(al ? "R5 luma word" : "R4 luma word", y_buf[i], al ? b + 2*i + 1 : b + 2*i);
        check(al ? "R5 chroma word" : "R4 chroma word", c_buf[i], al ? b + 2*i : b + 2*i + 1);
        check(al ? "R5 Cr flag" : "R4 Cr flag", cr_buf[i], i % 2);
      end
    end
    align_cb = 1'b0;
    check("R1 hsync after end code", hsync_o, 1);
    check("R1 vsync clear", vsync_o, 0);

    // R3 vertical blank line is silent; R1 flags
    clr();
    begin
      logic [9:0] a [8];
      for (int i = 0; i < 8; i++) a[i] = 10'h200 + 10'(i);
      send_line(1'b1, 1'b1, a);
    end
    close_line(1'b1, 1'b1);
    check("R3 no luma in vblank", y_cnt, 0);
    check("R3 no chroma in vblank", c_cnt, 0);
    check("R1 vsync set", vsync_o, 1);
    check("R1 field set", field_o, 1);

    // R2 lone 3FF and partial code pass as data
    clr();
    begin
      logic [9:0] a [8];
      a = '{10'h050, 10'h3FF, 10'h000, 10'h201, 10'h3FF, 10'h3FF, 10'h000, 10'h123};
      send_line(1'b0, 1'b0, a);
    end
    close_line(1'b0, 1'b0);
    check("R2 y count", y_cnt, 4);
    check("R2 luma0", y_buf[0], 10'h050);
    check("R2 chroma0 is 3FF", c_buf[0], 10'h3FF);
    check("R2 luma1", y_buf[1], 10'h000);
    check("R2 chroma1", c_buf[1], 10'h201);
    check("R2 luma2 is 3FF", y_buf[2], 10'h3FF);
    check("R2 chroma3", c_buf[3], 10'h123);

    // R7 lock
    do_reset();
    send_frame();
    check("R7 not locked after one frame", locked, 0);
    send_frame();
    check("R7 locked after second frame", locked, 1);

    // R8 free-run with a code-free stream
    align_cb = 1'b1;
    #1;
    check("R8 free_run", free_run, 1);
    for (int i = 0; i < 20; i++) drive(10'h123);
    clr();
    for (int i = 0; i < 200; i++) drive(10'h123);
    check("R8 luma per two frames", y_cnt, 24);
    check("R8 chroma per two frames", c_cnt, 24);
    check("R8 data", y_buf[0], 10'h123);
    check("R5 free-run Cb first", cr_buf[0], 0);
    check("R5 free-run Cr second", cr_buf[1], 1);

    // R10 reset clears lock
    do_reset();
    @(negedge clk);
    check("R10 locked cleared", locked, 0);
    check("R10 free_run cleared", free_run, 0);
    check("R10 y_valid cleared", y_valid, 0);

    // R9 separate-sync mode; R6 latency
    align_cb = 1'b0; sep_sync = 1'b1;
    do_reset();
    for (int i = 0; i < 4; i++) ext_drive(10'h040, 1'b1);
    clr();
    begin
      logic [9:0] a [8];
      int t0;
      a = '{10'h3FF, 10'h000, 10'h000, 10'h200, 10'h011, 10'h022, 10'h033, 10'h044};
      ext_drive(a[0], 1'b0);
      t0 = cyc;
      for (int i = 1; i < 8; i++) ext_drive(a[i], 1'b0);
      for (int i = 0; i < 6; i++) ext_drive(10'h040, 1'b1);
      check("R6 latency", y_first - t0, 4);
      check("R9 y count", y_cnt, 4);
      check("R9 c count", c_cnt, 4);
      check("R9 code word passed", y_buf[0], 10'h3FF);
      check("R9 luma1", y_buf[1], 10'h000);
      check("R9 chroma1 XY passed", c_buf[1], 10'h200);
      check("R9 Cr flag", cr_buf[1], 1);
      check("R9 hsync follows", hsync_o, 1);
    end
    check("R9 no lock in separate mode", locked, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule